// File: doc/BRIEF.md
# Paged Direct Address Generator

This block turns the short operand offset carried in an instruction word into a full data-memory address. The offset is 7 bits wide and the address is 16 bits wide. The data space is treated as 512 pages of 128 words. Two status-selected modes share the same offset field. In page mode, a 9-bit page register supplies the upper address bits. In stack mode, the offset is added to a 16-bit stack pointer.

A separate register-access flag overrides both modes. When it is set, the offset always lands in page 0. That page holds the control registers at 0x0000–0x005F and scratch words at 0x0060–0x007F.

A request strobe starts each address calculation. The result appears on a registered output, together with a one-cycle valid pulse, on the clock after the strobe. Requests may arrive on every cycle. Loading the page register and the stack pointer is done elsewhere, and so is the memory access itself.

The sequencing is a two-state machine:
- `ST_IDLE`: no result is pending.
- `ST_ISSUE`: a result is being presented.

Its transitions are:
- `REQ_SEEN` (`ST_IDLE`→`ST_ISSUE`) when a strobe arrives.
- `REQ_AGAIN` (`ST_ISSUE`→`ST_ISSUE`) for back-to-back strobes.
- `REQ_GONE` (`ST_ISSUE`→`ST_IDLE`) when no strobe arrives.

Top module: `direct_addr_gen`

## Requirements
- R1: In page mode (`stk_mode_i`=0, `regacc_i`=0), the address is `page_i` in bits 15:7 with `ofs_i` in bits 6:0.
- R2: In stack mode (`stk_mode_i`=1, `regacc_i`=0), the address is `stkptr_i` plus `ofs_i`.
- R3: The stack-mode sum zero-extends the offset and wraps modulo 2^16. For example, 0xFFF0 + 0x7F gives 0x006F.
- R4: With `regacc_i`=1, the address is `ofs_i` in bits 6:0 with bits 15:7 zero. `page_i`, `stkptr_i` and `stk_mode_i` have no effect.
- R5: Each strobe on `req_i` produces `vld_o`=1 and the new `addr_o` on the following clock, sampled after that edge.
- R6: `vld_o` is 0 in any cycle that follows a cycle without a strobe.
- R7: `addr_o` keeps its last value while no strobe arrives.
- R8: While `rst_n` is low, and until the first strobe, `addr_o` is 0x0000 and `vld_o` is 0.
- R9: In page mode, a page value of 2 with an offset of 1 yields address 0x0101.
- R10: Strobes on consecutive cycles each produce their own result on consecutive cycles, with `vld_o` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Address request strobe |
| ofs_i | input | 7 | Offset field from the instruction |
| page_i | input | 9 | Data-page register value |
| stkptr_i | input | 16 | Stack pointer value |
| stk_mode_i | input | 1 | 0 selects page mode, 1 selects stack mode |
| regacc_i | input | 1 | Register-space access; forces page 0 |
| addr_o | output | 16 | Registered operand address |
| vld_o | output | 1 | High for the cycle in which `addr_o` carries a new result |

## Verification
The bench builds the block with its default widths: a 7-bit offset, a 16-bit address and a 9-bit page.

These widths let the bench sweep every one of the 128 offsets under several page values, including page 0x1FF. It also sweeps every offset under stack pointers such as 0xFF90 and 0xFFFF, which brings the wrap of the 16-bit sum into reach.

Register accesses are driven with deliberately conflicting page, stack and mode inputs. Idle gaps and unbroken strobe runs alternate, so the hold behaviour and every state transition are exercised.

// File: rtl/dag_pkg.sv
package dag_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } dag_state_e;

    typedef enum logic [1:0] {
        SRC_PAGE  = 2'd0,
        SRC_STACK = 2'd1,
        SRC_REG   = 2'd2
    } dag_src_e;

endpackage

// File: rtl/dag_page_join.sv
module dag_page_join #(
    parameter int OFS_W  = 7,
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-OFS_W-1:0] page_i,
    input  logic [OFS_W-1:0]        ofs_i,
    output logic [ADDR_W-1:0]       addr_o
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    generate
        if (PAGE_W > 0) begin : g_join
            assign addr_o = {page_i, ofs_i};
        end else begin : g_flat
            assign addr_o = ofs_i[ADDR_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/dag_stack_add.sv
module dag_stack_add #(
    parameter int OFS_W  = 7,
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] stkptr_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    assign ofs_ext = {{PAD_W{1'b0}}, ofs_i};
    // The carry out of the top bit is dropped, so the sum wraps.
    assign addr_o  = stkptr_i + ofs_ext;

endmodule

// File: rtl/dag_ctrl.sv
module dag_ctrl
    import dag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic load_o,
    output logic vld_o
);
    dag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_i)  state_d = ST_ISSUE;   // REQ_SEEN
            ST_ISSUE: if (!req_i) state_d = ST_IDLE;    // REQ_GONE, else REQ_AGAIN
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o = req_i;
        vld_o  = (state_q == ST_ISSUE);
    end

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> vld_o);                                         // R5
    AST_NO_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !vld_o);                                       // R6

endmodule

// File: rtl/direct_addr_gen.sv
module direct_addr_gen
    import dag_pkg::*;
#(
    parameter int OFS_W  = 7,
    parameter int ADDR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_i,
    input  logic [OFS_W-1:0]        ofs_i,
    input  logic [ADDR_W-OFS_W-1:0] page_i,
    input  logic [ADDR_W-1:0]       stkptr_i,
    input  logic                    stk_mode_i,
    input  logic                    regacc_i,
    output logic [ADDR_W-1:0]       addr_o,
    output logic                    vld_o
);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] page_addr, stack_addr, reg_addr, addr_d, addr_q;
    logic              load;
    dag_src_e          src;

    dag_page_join #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_page (
        .page_i (page_i),
        .ofs_i  (ofs_i),
        .addr_o (page_addr)
    );

    dag_stack_add #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_stack (
        .stkptr_i (stkptr_i),
        .ofs_i    (ofs_i),
        .addr_o   (stack_addr)
    );

    // Page-0 form: the register-access override uses a zero page.
    dag_page_join #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) u_reg (
        .page_i ({PAGE_W{1'b0}}),
        .ofs_i  (ofs_i),
        .addr_o (reg_addr)
    );

    dag_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .load_o (load),
        .vld_o  (vld_o)
    );

    // Register access has priority over both modes.
    always_comb begin
        if (regacc_i)        src = SRC_REG;
        else if (stk_mode_i) src = SRC_STACK;
        else                 src = SRC_PAGE;
    end

    always_comb begin
        unique case (src)
            SRC_REG:   addr_d = reg_addr;
            SRC_STACK: addr_d = stack_addr;
            default:   addr_d = page_addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    AST_PAGE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !regacc_i && !stk_mode_i) |=>
            (addr_o == {$past(page_i), $past(ofs_i)}));                          // R1
    AST_STACK_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !regacc_i && stk_mode_i) |=>
            (addr_o == ADDR_W'($past(stkptr_i) + ADDR_W'($past(ofs_i)))));       // R3
    AST_REG_PAGE0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && regacc_i) |=>
            (addr_o[ADDR_W-1:OFS_W] == '0 && addr_o[OFS_W-1:0] == $past(ofs_i))); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(addr_o));                                             // R7

endmodule

// File: tb/direct_addr_gen_tb_top.sv
module direct_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [6:0]  ofs = '0;
    logic [8:0]  page = '0;
    logic [15:0] sp = '0;
    logic        smode = 1'b0;
    logic        racc = 1'b0;
    logic [15:0] addr;
    logic        vld;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    int    exp_addr = 0;
    bit    exp_vld  = 0;
    string exp_tag  = "R8";
    bit    model_on = 0;

    always #5 clk = ~clk;

    direct_addr_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .ofs_i      (ofs),
        .page_i     (page),
        .stkptr_i   (sp),
        .stk_mode_i (smode),
        .regacc_i   (racc),
        .addr_o     (addr),
        .vld_o      (vld)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference, advanced once per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_addr = 0; exp_vld = 0; exp_tag = "R8";
        end else if (req) begin
            exp_vld = 1;
            if (racc) begin
                exp_addr = ofs; exp_tag = "R4";
            end else if (smode) begin
                exp_addr = (int'(sp) + int'(ofs)) % 65536; exp_tag = "R2";
            end else begin
                exp_addr = int'(page) * 128 + int'(ofs); exp_tag = "R1";
            end
        end else begin
            exp_vld = 0; exp_tag = "R7";
        end
    end

    // Compared away from the active edge, on every cycle.
    always @(negedge clk) begin
        if (model_on) begin
            check(exp_vld ? "R5" : "R6", int'(vld), int'(exp_vld));
            check(exp_tag, int'(addr), exp_addr);
        end
    end

    task automatic drive(input bit r, input int o, input int p, input int s,
                         input bit m, input bit ra);
        @(negedge clk);
        req = r; ofs = 7'(o); page = 9'(p); sp = 16'(s); smode = m; racc = ra;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int pages [4] = '{0, 2, 9'h0AA, 9'h1FF};
        int sps   [4] = '{0, 16'h1234, 16'hFF90, 16'hFFFF};

        repeat (3) @(negedge clk);
        check("R8", int'(addr), 0);
        check("R8", int'(vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", int'(addr), 0);
        check("R8", int'(vld), 0);
        model_on = 1;

        // R9: worked example in page mode
        drive(1, 1, 2, 16'hBEEF, 0, 0);
        drive(0, 0, 0, 0, 0, 0);
        check("R9", int'(addr), 16'h0101);
        check("R9", int'(vld), 1);

        // R1: every offset under several pages, back-to-back (R10)
        foreach (pages[i]) begin
            for (int o = 0; o < 128; o++) drive(1, o, pages[i], 16'h5555, 0, 0);
            drive(0, 0, 0, 0, 0, 0);
        end

        // R2 / R3: every offset under several stack pointers, including wrap
        foreach (sps[i]) begin
            for (int o = 0; o < 128; o++) drive(1, o, 9'h155, sps[i], 1, 0);
            drive(0, 0, 0, 0, 0, 0);
        end
        drive(1, 7'h7F, 0, 16'hFFF0, 1, 0);
        drive(0, 0, 0, 0, 0, 0);
        check("R3", int'(addr), 16'h006F);

        // R4: register access with conflicting page, stack and mode inputs
        for (int o = 0; o < 128; o++)
            drive(1, o, 9'h1FF - o, 16'hFFFF - o * 3, o[0], 1);
        drive(0, 0, 0, 0, 0, 0);
        drive(1, 7'h65, 9'h1FF, 16'hFFFF, 1, 1);
        drive(0, 7'h11, 9'h1FF, 16'hFFFF, 1, 1);
        check("R4", int'(addr), 16'h0065);

        // R7: hold while the inputs move without a strobe
        for (int k = 0; k < 8; k++) drive(0, k * 9, k * 40, k * 4000, k[0], k[1]);
        check("R7", int'(addr), 16'h0065);
        check("R6", int'(vld), 0);

        // R10: alternating modes on consecutive cycles
        drive(1, 3, 5, 16'h0100, 0, 0);
        drive(1, 3, 5, 16'h0100, 1, 0);
        check("R10", int'(addr), 16'h0283);
        drive(1, 3, 5, 16'h0100, 1, 1);
        check("R10", int'(addr), 16'h0103);
        drive(0, 0, 0, 0, 0, 0);
        check("R10", int'(addr), 16'h0003);
        check("R10", int'(vld), 1);
        drive(0, 0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule